// File: doc/BRIEF.md
# SCSI Initiator Command and Interrupt Register Unit

This block is the byte-wide register front end of a simple SCSI initiator controller. A host writes and reads sixteen byte offsets. Several offsets hold one register on the read side and another on the write side, so the unit keeps a full write-side copy of every offset next to the read-side registers. Writing the command offset executes an operation at once. The operation updates the status, interrupt and sequence registers. It can also raise a level interrupt.

Selection does not drive a real bus. It looks up the target number in a presence vector and reports either a connect or a disconnect. Reading the interrupt offset has a side effect: it acknowledges the interrupt. One configuration bit keeps a bus reset from interrupting the host. Read data is registered and appears one cycle after the read strobe. A write in the same cycle as a read takes priority, and the read is then ignored.

Top module: `scc_ctrl_regs`

## Requirements
- R1: After reset every read-side offset reads 0x00 except offset 0xE, which reads 0x04. irq, dma_mode and cmd_collect are low.
- R2: A read strobe without a write returns the stored read-side value of the offset on rdata one clock later.
- R3: Reading offset 5 (interrupt register) clears status bits 7, 6 and 5 (status is offset 4) and drops irq by the next cycle.
- R4: irq always equals status bit 7. A raise while irq is already high keeps it high with no low cycle in between. Only a read of offset 5 or a chip reset lowers it.
- R5: Command opcode 0x02 clears all read-side and write-side registers and sets offset 0xE to 0x04. It also clears dma_mode and cmd_collect and drops irq. The command offset then reads 0x00.
- R6: Opcode 0x01 sets the interrupt register to 0x08 and clears offsets 6 and 7. It does not raise irq.
- R7: Opcode 0x03 sets the interrupt register to 0x80. It raises irq only when bit 6 of offset 8 is 0.
- R8: Opcodes 0x42 and 0x43 take the target number from bits 2:0 of the last write to offset 4. If the matching tgt_present bit is 0, the result is: status 0x00, then raised, so it reads 0x80; interrupt register 0x20; offset 6 = 0; irq high.
- R9: Opcode 0x42 with the target present sets the interrupt register to 0x18 and offset 6 to 4, and raises irq.
- R10: Opcode 0x43 with the target present does the same as R9. It also sets status to 0x12 (reads 0x92 with irq) and sets cmd_collect. While cmd_collect is set, opcode 0x10 clears it and sets the interrupt register to 0x18 and offset 6 to 4, and raises irq.
- R11: Writes to offset 0xB keep only the bits of mask 0x15. Writes to offset 8 and to 0xC–0xF are stored as written. Writes to offsets 4–7, 9 and 0xA leave every read-side value unchanged.
- R12: Offset 3 reads back the last command byte. Bit 7 of a command byte sets dma_mode and copies the write-side values of offsets 0 and 1 into their read side. A write to offset 0 or 1 clears status bit 4.
- R13: Opcodes 0x11 and 0x12 without bit 7 set offset 7 to 2 and raise irq. Opcode 0x12 then also sets the interrupt register to 0x20 and offset 6 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Register offset |
| wdata | input | DW | Write data |
| tgt_present | input | NUM_TGT | One bit per target that answers selection |
| rdata | output | DW | Registered read data |
| irq | output | 1 | Level interrupt, equal to status bit 7 |
| dma_mode | output | 1 | DMA flag of the last command |
| cmd_collect | output | 1 | Command-collection mode after select-and-stop |

## Verification
A wrong internal state shows up in three ways. It may give a wrong byte on rdata one cycle after the read of the affected offset. It may give a wrong level on irq, dma_mode or cmd_collect in the cycle after the command write. Or it may stay latent until a later access exposes it: a stale write-side copy is only seen once a DMA-flagged command reloads the counter or a selection uses the bus ID. The sequences therefore follow every command with readbacks of the status, interrupt, sequence and flags offsets. Deferred effects are exercised explicitly: a reload after a chip reset, and a second selection while irq is still high.

// File: rtl/scc_pkg.sv
package scc_pkg;
  localparam int unsigned OFS_CNT_LO = 0;
  localparam int unsigned OFS_CNT_MI = 1;
  localparam int unsigned OFS_CMD    = 3;
  localparam int unsigned OFS_STAT   = 4;  // read side: status, write side: bus id
  localparam int unsigned OFS_INTR   = 5;
  localparam int unsigned OFS_SEQ    = 6;
  localparam int unsigned OFS_FLAGS  = 7;
  localparam int unsigned OFS_CFG1   = 8;
  localparam int unsigned OFS_CFG2   = 11;
  localparam int unsigned OFS_ID     = 14;

  localparam logic [7:0] ID_VALUE   = 8'h04;
  localparam logic [7:0] CFG2_KEEP  = 8'h15;
  localparam logic [7:0] INT_FDONE  = 8'h08;
  localparam logic [7:0] INT_CONN   = 8'h18;
  localparam logic [7:0] INT_DISC   = 8'h20;
  localparam logic [7:0] INT_BRST   = 8'h80;
  localparam logic [7:0] ST_CMDPH   = 8'h12;
  localparam logic [7:0] ST_STATPH  = 8'h13;
  localparam logic [7:0] SEQ_DONE   = 8'h04;
  localparam int unsigned ST_TC_BIT = 4;
  localparam int unsigned ST_IRQ_BIT = 7;
  localparam int unsigned CFG1_QUIET_BIT = 6;

  typedef enum logic [3:0] {
    OP_NOP, OP_FLUSH, OP_CHIPRST, OP_BUSRST, OP_XFER, OP_CMPL,
    OP_MSGOK, OP_ATN, OP_SEL, OP_SELSTOP, OP_ENSEL, OP_OTHER
  } op_e;
endpackage

// File: rtl/scc_cmd_decode.sv
module scc_cmd_decode
  import scc_pkg::*;
(
  input  logic [6:0] opcode,
  output op_e        op
);
  always_comb begin
    case (opcode)
      7'h00:   op = OP_NOP;
      7'h01:   op = OP_FLUSH;
      7'h02:   op = OP_CHIPRST;
      7'h03:   op = OP_BUSRST;
      7'h10:   op = OP_XFER;
      7'h11:   op = OP_CMPL;
      7'h12:   op = OP_MSGOK;
      7'h1A:   op = OP_ATN;
      7'h42:   op = OP_SEL;
      7'h43:   op = OP_SELSTOP;
      7'h44:   op = OP_ENSEL;
      default: op = OP_OTHER;
    endcase
  end
endmodule

// File: rtl/scc_tgt_lookup.sv
module scc_tgt_lookup #(
  parameter int unsigned NUM_TGT = 8,
  localparam int unsigned TGT_W = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
  input  logic [NUM_TGT-1:0] present,
  input  logic [TGT_W-1:0]   tgt_id,
  output logic               hit
);
  logic [NUM_TGT-1:0] match;
  for (genvar g = 0; g < NUM_TGT; g++) begin : g_match
    assign match[g] = present[g] && (tgt_id == TGT_W'(g));
  end
  assign hit = |match;
endmodule

// File: rtl/scc_ctrl_regs.sv
module scc_ctrl_regs
  import scc_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8,
  parameter int unsigned NUM_TGT = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  input  logic [NUM_TGT-1:0] tgt_present,
  output logic [DW-1:0]      rdata,
  output logic               irq,
  output logic               dma_mode,
  output logic               cmd_collect
);
  localparam int unsigned NREG  = 1 << AW;
  localparam int unsigned TGT_W = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1;

  logic [DW-1:0] rd_q [NREG];
  logic [DW-1:0] rd_d [NREG];
  logic [DW-1:0] wr_q [NREG];
  logic [DW-1:0] wr_d [NREG];
  logic          dma_q, dma_d, coll_q, coll_d, raise;
  op_e           op;
  logic          tgt_hit;

  scc_cmd_decode u_dec (.opcode(wdata[6:0]), .op(op));

  scc_tgt_lookup #(.NUM_TGT(NUM_TGT)) u_tgt (
    .present(tgt_present),
    .tgt_id (wr_q[OFS_STAT][TGT_W-1:0]),
    .hit    (tgt_hit)
  );

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    dma_d = dma_q;
    coll_d = coll_q;
    raise = 1'b0;
    if (wr_en) begin
      if (addr == AW'(OFS_CNT_LO) || addr == AW'(OFS_CNT_MI)) begin
        rd_d[OFS_STAT][ST_TC_BIT] = 1'b0;
      end else if (addr == AW'(OFS_CMD)) begin
        rd_d[OFS_CMD] = wdata;
        dma_d = wdata[DW-1];
        if (wdata[DW-1]) begin
          rd_d[OFS_CNT_LO] = wr_q[OFS_CNT_LO];
          rd_d[OFS_CNT_MI] = wr_q[OFS_CNT_MI];
        end
        case (op)
          OP_FLUSH: begin
            rd_d[OFS_INTR]  = INT_FDONE;
            rd_d[OFS_SEQ]   = '0;
            rd_d[OFS_FLAGS] = '0;
          end
          OP_CHIPRST: begin
            for (int i = 0; i < NREG; i++) begin
              rd_d[i] = '0;
              wr_d[i] = '0;
            end
            rd_d[OFS_ID] = ID_VALUE;
            dma_d  = 1'b0;
            coll_d = 1'b0;
          end
          OP_BUSRST: begin
            rd_d[OFS_INTR] = INT_BRST;
            raise = !rd_q[OFS_CFG1][CFG1_QUIET_BIT];
          end
          OP_XFER: begin
            if (wdata[DW-1]) rd_d[OFS_STAT][ST_TC_BIT] = 1'b0;
            if (coll_q) begin
              coll_d = 1'b0;
              rd_d[OFS_INTR] = INT_CONN;
              rd_d[OFS_SEQ]  = SEQ_DONE;
              raise = 1'b1;
            end
          end
          OP_CMPL, OP_MSGOK: begin
            if (wdata[DW-1]) begin
              rd_d[OFS_STAT] = ST_STATPH;
              rd_d[OFS_INTR] = INT_CONN;
              rd_d[OFS_SEQ]  = SEQ_DONE;
            end else begin
              rd_d[OFS_FLAGS] = 8'h02;
            end
            raise = 1'b1;
            if (op == OP_MSGOK) begin
              rd_d[OFS_INTR] = INT_DISC;
              rd_d[OFS_SEQ]  = '0;
            end
          end
          OP_SEL, OP_SELSTOP: begin
            raise = 1'b1;
            if (!tgt_hit) begin
              rd_d[OFS_STAT] = '0;
              rd_d[OFS_INTR] = INT_DISC;
              rd_d[OFS_SEQ]  = '0;
            end else begin
              rd_d[OFS_INTR] = INT_CONN;
              rd_d[OFS_SEQ]  = SEQ_DONE;
              if (op == OP_SELSTOP) begin
                rd_d[OFS_STAT] = ST_CMDPH;
                coll_d = 1'b1;
              end
            end
          end
          default: ;
        endcase
      end else if (addr == AW'(OFS_CFG1)) begin
        rd_d[OFS_CFG1] = wdata;
      end else if (addr == AW'(OFS_CFG2)) begin
        rd_d[OFS_CFG2] = wdata & CFG2_KEEP;
      end else if (addr >= AW'(12)) begin
        rd_d[addr] = wdata;
      end
      wr_d[addr] = wdata;
    end else if (rd_en && addr == AW'(OFS_INTR)) begin
      rd_d[OFS_STAT] = rd_q[OFS_STAT] & 8'h1F;
    end
    if (raise) rd_d[OFS_STAT][ST_IRQ_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        rd_q[i] <= (i == OFS_ID) ? ID_VALUE : '0;
        wr_q[i] <= '0;
      end
      dma_q  <= 1'b0;
      coll_q <= 1'b0;
      rdata  <= '0;
    end else begin
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      dma_q  <= dma_d;
      coll_q <= coll_d;
      if (rd_en && !wr_en) rdata <= rd_q[addr];
    end
  end

  assign irq         = rd_q[OFS_STAT][ST_IRQ_BIT];
  assign dma_mode    = dma_q;
  assign cmd_collect = coll_q;
endmodule

// File: rtl/scc_ctrl_regs_chk.sv
module scc_ctrl_regs_chk #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic          irq,
  input logic          dma_mode,
  input logic          cmd_collect
);
  logic cmd_wr, ack_rd, chip_rst;
  assign cmd_wr   = wr_en && addr == AW'(3);
  assign ack_rd   = rd_en && !wr_en && addr == AW'(5);
  assign chip_rst = cmd_wr && wdata[6:0] == 7'h02;

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!irq && !dma_mode && !cmd_collect));

  assert_ack_drops_irq_R3: assert property (@(posedge clk) disable iff (rst)
    ack_rd |=> !irq);

  assert_irq_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (irq && !ack_rd && !chip_rst) |=> irq);

  assert_chip_reset_R5: assert property (@(posedge clk) disable iff (rst)
    chip_rst |=> (!irq && !dma_mode && !cmd_collect));

  assert_dma_flag_R12: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |=> (dma_mode == $past(wdata[DW-1])));
endmodule

bind scc_ctrl_regs scc_ctrl_regs_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/scc_ctrl_regs_tb_top.sv
module scc_ctrl_regs_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] tgt_present = 8'b0000_0110;
  logic [7:0] rdata;
  logic       irq, dma_mode, cmd_collect;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic rd_seen = 1'b0;

  typedef struct { logic [7:0] exp; logic [3:0] a; string tag; } item_t;
  item_t sbq[$];

  always #(CLK_P/2) clk = ~clk;

  scc_ctrl_regs dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .tgt_present(tgt_present), .rdata(rdata), .irq(irq),
    .dma_mode(dma_mode), .cmd_collect(cmd_collect)
  );

  task automatic chk_eq(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    sbq.push_back('{exp: e, a: a, tag: tag});
    @(negedge clk); rd_en = 1'b0;
  endtask

  always @(posedge clk) rd_seen <= rd_en && !wr_en && !rst;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (sbq.size() == 0) begin
        checks++; failures++;
        $display("FAIL R2: unexpected read result 0x%02h expected none", rdata);
      end else begin
        item_t it;
        it = sbq.pop_front();
        chk_eq(rdata, it.exp, $sformatf("%s read of offset 0x%0h", it.tag, it.a));
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_eq({7'd0, irq}, 8'd0, "R1 irq");
    chk_eq({7'd0, dma_mode}, 8'd0, "R1 dma_mode");
    chk_eq({7'd0, cmd_collect}, 8'd0, "R1 cmd_collect");
    for (int i = 0; i < 16; i++) rd(4'(i), (i == 14) ? 8'h04 : 8'h00, "R1");

    // R11 register write storage rules
    wr(4'hB, 8'hFF); rd(4'hB, 8'h15, "R11");
    wr(4'hC, 8'hA5); rd(4'hC, 8'hA5, "R11");
    wr(4'hF, 8'h3C); rd(4'hF, 8'h3C, "R11");
    wr(4'h8, 8'h00); rd(4'h8, 8'h00, "R11");
    wr(4'h4, 8'h07); rd(4'h4, 8'h00, "R11");
    wr(4'h9, 8'hFF); rd(4'h9, 8'h00, "R11");
    wr(4'h7, 8'hFF); rd(4'h7, 8'h00, "R11");

    // R8 selection miss (target 7 absent)
    wr(4'h3, 8'h42);
    chk_eq({7'd0, irq}, 8'd1, "R8 irq");
    rd(4'h4, 8'h80, "R8");
    rd(4'h6, 8'h00, "R8");
    rd(4'h3, 8'h42, "R12");
    rd(4'h5, 8'h20, "R8");
    chk_eq({7'd0, irq}, 8'd0, "R3 irq after ack");
    rd(4'h4, 8'h00, "R3");

    // R9 selection hit, R4 repeated raise
    wr(4'h4, 8'h02);
    wr(4'h3, 8'h42);
    chk_eq({7'd0, irq}, 8'd1, "R9 irq");
    wr(4'h3, 8'h42);
    chk_eq({7'd0, irq}, 8'd1, "R4 irq held");
    rd(4'h6, 8'h04, "R9");
    chk_eq({7'd0, irq}, 8'd1, "R4 irq held after other read");
    rd(4'h5, 8'h18, "R9");
    chk_eq({7'd0, irq}, 8'd0, "R3 irq after ack");

    // R10 select-and-stop, then transfer ends collection
    wr(4'h3, 8'h43);
    chk_eq({7'd0, cmd_collect}, 8'd1, "R10 cmd_collect");
    rd(4'h4, 8'h92, "R10");
    rd(4'h5, 8'h18, "R10");
    rd(4'h6, 8'h04, "R10");
    rd(4'h4, 8'h12, "R3");
    wr(4'h0, 8'h34);
    rd(4'h4, 8'h02, "R12");
    rd(4'h0, 8'h00, "R12");
    wr(4'h3, 8'h10);
    chk_eq({7'd0, cmd_collect}, 8'd0, "R10 collection ended");
    chk_eq({7'd0, irq}, 8'd1, "R10 irq");
    rd(4'h5, 8'h18, "R10");
    rd(4'h6, 8'h04, "R10");

    // R12 DMA flag and counter reload
    wr(4'h1, 8'h12);
    wr(4'h3, 8'h80);
    chk_eq({7'd0, dma_mode}, 8'd1, "R12 dma_mode");
    rd(4'h0, 8'h34, "R12");
    rd(4'h1, 8'h12, "R12");
    rd(4'h3, 8'h80, "R12");
    wr(4'h3, 8'h00);
    chk_eq({7'd0, dma_mode}, 8'd0, "R12 dma_mode clear");
    rd(4'h3, 8'h00, "R2");

    // R13 completion response, then R6 flush
    wr(4'h3, 8'h11);
    chk_eq({7'd0, irq}, 8'd1, "R13 irq");
    rd(4'h7, 8'h02, "R13");
    rd(4'h5, 8'h18, "R13");
    wr(4'h3, 8'h01);
    chk_eq({7'd0, irq}, 8'd0, "R6 no irq");
    rd(4'h5, 8'h08, "R6");
    rd(4'h6, 8'h00, "R6");
    rd(4'h7, 8'h00, "R6");

    // R13 message accepted
    wr(4'h3, 8'h12);
    chk_eq({7'd0, irq}, 8'd1, "R13 irq");
    rd(4'h7, 8'h02, "R13");
    rd(4'h6, 8'h00, "R13");
    rd(4'h5, 8'h20, "R13");

    // R7 bus reset with and without quiet bit
    wr(4'h8, 8'h40);
    wr(4'h3, 8'h03);
    chk_eq({7'd0, irq}, 8'd0, "R7 suppressed");
    rd(4'h5, 8'h80, "R7");
    rd(4'h8, 8'h40, "R11");
    wr(4'h8, 8'h00);
    wr(4'h3, 8'h03);
    chk_eq({7'd0, irq}, 8'd1, "R7 raised");
    rd(4'h5, 8'h80, "R7");

    // R5 chip reset
    wr(4'h3, 8'hC3);
    chk_eq({7'd0, cmd_collect}, 8'd1, "R5 setup collect");
    chk_eq({7'd0, dma_mode}, 8'd1, "R5 setup dma");
    wr(4'h3, 8'h02);
    chk_eq({7'd0, irq}, 8'd0, "R5 irq");
    chk_eq({7'd0, dma_mode}, 8'd0, "R5 dma_mode");
    chk_eq({7'd0, cmd_collect}, 8'd0, "R5 cmd_collect");
    rd(4'hE, 8'h04, "R5");
    rd(4'hC, 8'h00, "R5");
    rd(4'hB, 8'h00, "R5");
    rd(4'h3, 8'h00, "R5");
    rd(4'h0, 8'h00, "R5");
    wr(4'h3, 8'h80);
    rd(4'h0, 8'h00, "R5");

    repeat (2) @(negedge clk);
    chk_eq(8'(sbq.size()), 8'd0, "R2 pending reads");
    done = 1'b1;
    summary();
    $finish;
  end
endmodule